// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Aperture

This block is the register-mapped side of message-signalled interrupt delivery for a 128-trigger interrupt controller. It answers APB accesses to a 128-entry vector table, where each trigger owns one 16-byte entry, to a four-word read-only image of the captured cause bits, and to a 3-bit traffic-class register. The cause bits are captured elsewhere and arrive as a 128-bit input.

Each table entry stores a 5-bit vector number and a mask bit. The mask bit is the same storage as the matching bit of the group mask registers kept by the neighbouring control logic. That logic writes into it through a per-bit update port and reads it back from `maskOut`, so a change made from either view shows in the other. A downstream message generator reads any trigger's vector and mask combinationally through a lookup port. Trigger `t` belongs to group `t/32`, bit `t%32`. The table is packed by flat trigger number across all groups, while the pending image is laid out one word per group.

Top module: `msix_aperture`

## Requirements
- R1: Byte addresses 0x800 to 0xFFF select the table: entry = address bits 10:4 (trigger 0..127), word = address bits 3:2, byte = bits 1:0. Every access completes in one access phase (`pready` is always 1).
- R2: Word 2 of entry t (address 0x808 + 16t) holds a read/write vector number in bits 4:0 that resets to 0. Written bits 31:5 are dropped and read as 0.
- R3: Word 3 of entry t (address 0x80C + 16t) bit 0 is the mask of trigger t. It resets to 1, reads back in bit 0 with bits 31:1 zero, and a table write to it changes `maskOut[t]` on the next cycle.
- R4: A cycle with `grpMaskWe[t]` = 1 loads `grpMaskWd[t]` into the mask of trigger t. The new value is visible through table word 3 of entry t and on `maskOut[t]`, and no other trigger's mask changes.
- R5: When a table write to word 3 of entry t and `grpMaskWe[t]` fall in the same cycle, the table write data decides the mask of trigger t. Group updates to other triggers in that cycle still take effect.
- R6: Entry words 0 and 1 read as zero, and writes to them change neither the entry's vector nor its mask.
- R7: Address 0x3F0 + 4g (g = 0..3) reads `causeIn[32g+31:32g]`. Writes there have no effect.
- R8: Address 0x3E0 holds a 3-bit traffic class in bits 2:0 that resets to 0 and drives `trafficClass`. Other bits read 0.
- R9: `lookupVec` and `lookupMask` show the vector and mask of entry `lookupIdx` in the same cycle, with no register stage.
- R10: All other addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| causeIn | input | 128 | Captured cause bits, bit t = trigger t |
| grpMaskWe | input | 128 | Per-trigger mask update enable from the group mask registers |
| grpMaskWd | input | 128 | Per-trigger mask update value |
| maskOut | output | 128 | Current mask of every trigger |
| trafficClass | output | 3 | Traffic class for message writes |
| lookupIdx | input | 7 | Trigger index for the lookup port |
| lookupVec | output | 5 | Vector number of the looked-up entry |
| lookupMask | output | 1 | Mask of the looked-up entry |

## Verification
The hardest case to reach is a table write to a mask word landing in the very cycle that the group-mask side updates the same trigger to the opposite value. A second trigger is updated in that cycle too. The stimulus gets there by raising `grpMaskWe` and `grpMaskWd` at the falling edge that opens the APB access phase and dropping them right after the write edge, so both updates land on one clock edge. Table readback and `maskOut` then show which update won and that the bystander update still applied.

// File: rtl/msix_aperture_pkg.sv
package msix_aperture_pkg;
  localparam int NUM_TRIGS = 128;
  localparam int GRP_W     = 32;
  localparam int NUM_GRPS  = NUM_TRIGS / GRP_W;
  localparam int IDX_W     = $clog2(NUM_TRIGS);
  localparam int GRP_IDX_W = $clog2(NUM_GRPS);
  localparam int VEC_W     = 5;
  localparam int TC_W      = 3;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;

  typedef enum logic [2:0] {
    RD_ZERO, RD_VEC, RD_MASK, RD_PEND, RD_TC
  } rdSelE;

  typedef struct packed {
    logic                 vecWr;
    logic                 maskWr;
    logic                 tcWr;
    rdSelE                rdSel;
    logic [IDX_W-1:0]     entry;
    logic [GRP_IDX_W-1:0] pendGrp;
  } strobeS;
endpackage

// File: rtl/msix_aperture_ctrl.sv
module msix_aperture_ctrl
  import msix_aperture_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output strobeS            strb
);
  localparam logic [ADDR_W-1:0] PEND_BASE = 12'h3F0;
  localparam logic [ADDR_W-1:0] TC_ADDR   = 12'h3E0;
  localparam int                WORD_LSB  = 2;
  localparam int                ENT_LSB   = 4;

  logic       access;
  logic       inTable;
  logic       inPend;
  logic       inTc;
  logic [1:0] wordSel;

  assign access  = psel & penable;
  assign inTable = paddr[ADDR_W-1];
  assign wordSel = paddr[WORD_LSB +: 2];
  assign inPend  = (paddr[ADDR_W-1:ENT_LSB] == PEND_BASE[ADDR_W-1:ENT_LSB]);
  assign inTc    = (paddr[ADDR_W-1:WORD_LSB] == TC_ADDR[ADDR_W-1:WORD_LSB]);

  always_comb begin
    strb.entry   = paddr[ENT_LSB +: IDX_W];
    strb.pendGrp = paddr[WORD_LSB +: GRP_IDX_W];
    strb.vecWr   = access & pwrite & inTable & (wordSel == 2'd2);
    strb.maskWr  = access & pwrite & inTable & (wordSel == 2'd3);
    strb.tcWr    = access & pwrite & inTc;
    if (inTable && wordSel == 2'd2)      strb.rdSel = RD_VEC;
    else if (inTable && wordSel == 2'd3) strb.rdSel = RD_MASK;
    else if (inPend)                     strb.rdSel = RD_PEND;
    else if (inTc)                       strb.rdSel = RD_TC;
    else                                 strb.rdSel = RD_ZERO;
  end

  // R1, R10: at most one storage element written per access
  a_r1_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.vecWr, strb.maskWr, strb.tcWr}));
  // R1: table writes only from the upper half of the aperture
  a_r1_table_window: assert property (@(posedge clk) disable iff (!rstN)
    (strb.vecWr || strb.maskWr) |-> (paddr >= 12'h800));
endmodule

// File: rtl/msix_aperture_dp.sv
module msix_aperture_dp
  import msix_aperture_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeS               strb,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_TRIGS-1:0] causeIn,
  input  logic [NUM_TRIGS-1:0] grpMaskWe,
  input  logic [NUM_TRIGS-1:0] grpMaskWd,
  input  logic [IDX_W-1:0]     lookupIdx,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_TRIGS-1:0] maskOut,
  output logic [TC_W-1:0]      trafficClass,
  output logic [VEC_W-1:0]     lookupVec,
  output logic                 lookupMask
);
  logic [VEC_W-1:0]     vecMem [NUM_TRIGS];
  logic [NUM_TRIGS-1:0] maskReg;
  logic [NUM_TRIGS-1:0] maskNext;
  logic [NUM_TRIGS-1:0] tableHit;
  logic [TC_W-1:0]      tcReg;

  // vector storage, one register per entry
  for (genvar t = 0; t < NUM_TRIGS; t++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rstN)                                       vecMem[t] <= '0;
      else if (strb.vecWr && strb.entry == IDX_W'(t))  vecMem[t] <= wdata[VEC_W-1:0];
    end
  end

  // mask: group update first, table write overrides the same bit
  always_comb begin
    tableHit = '0;
    if (strb.maskWr) tableHit[strb.entry] = 1'b1;
    maskNext = (maskReg & ~grpMaskWe) | (grpMaskWd & grpMaskWe);
    maskNext = (maskNext & ~tableHit) | ({NUM_TRIGS{wdata[0]}} & tableHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskReg <= '1;
    else       maskReg <= maskNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          tcReg <= '0;
    else if (strb.tcWr) tcReg <= wdata[TC_W-1:0];
  end

  always_comb begin
    rdata = '0;
    unique case (strb.rdSel)
      RD_VEC:  rdata[VEC_W-1:0] = vecMem[strb.entry];
      RD_MASK: rdata[0]         = maskReg[strb.entry];
      RD_PEND: rdata            = causeIn[strb.pendGrp*GRP_W +: GRP_W];
      RD_TC:   rdata[TC_W-1:0]  = tcReg;
      default: rdata            = '0;
    endcase
  end

  assign maskOut      = maskReg;
  assign trafficClass = tcReg;
  assign lookupVec    = vecMem[lookupIdx];
  assign lookupMask   = maskReg[lookupIdx];

  // R5: the table write decides the addressed mask bit
  a_r5_table_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskWr |=> (maskOut[$past(strb.entry)] == $past(wdata[0])));
  // R4: mask bits change only where some update was requested
  a_r4_no_stray_change: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((maskOut ^ $past(maskOut)) & ~$past(grpMaskWe) & ~$past(tableHit)) == '0));
  // R8: traffic class holds without a write
  a_r8_tc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tcWr |=> $stable(trafficClass));
  // R2: a vector write reaches the lookup of that entry
  a_r2_vec_write: assert property (@(posedge clk) disable iff (!rstN)
    (strb.vecWr && lookupIdx == strb.entry) |=>
      (vecMem[$past(strb.entry)] == $past(wdata[VEC_W-1:0])));
endmodule

// File: rtl/msix_aperture.sv
module msix_aperture
  import msix_aperture_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [DATA_W-1:0]    pwdata,
  output logic [DATA_W-1:0]    prdata,
  output logic                 pready,
  input  logic [NUM_TRIGS-1:0] causeIn,
  input  logic [NUM_TRIGS-1:0] grpMaskWe,
  input  logic [NUM_TRIGS-1:0] grpMaskWd,
  output logic [NUM_TRIGS-1:0] maskOut,
  output logic [TC_W-1:0]      trafficClass,
  input  logic [IDX_W-1:0]     lookupIdx,
  output logic [VEC_W-1:0]     lookupVec,
  output logic                 lookupMask
);
  strobeS strb;

  assign pready = 1'b1;

  msix_aperture_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .strb    (strb)
  );

  msix_aperture_dp dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wdata        (pwdata),
    .causeIn      (causeIn),
    .grpMaskWe    (grpMaskWe),
    .grpMaskWd    (grpMaskWd),
    .lookupIdx    (lookupIdx),
    .rdata        (prdata),
    .maskOut      (maskOut),
    .trafficClass (trafficClass),
    .lookupVec    (lookupVec),
    .lookupMask   (lookupMask)
  );
endmodule

// File: tb/msix_aperture_tb.sv
module msix_aperture_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0]  paddr = '0;
  logic [31:0]  pwdata = '0;
  logic [31:0]  prdata;
  logic         pready;
  logic [127:0] causeIn = '0, grpMaskWe = '0, grpMaskWd = '0;
  logic [127:0] maskOut;
  logic [2:0]   trafficClass;
  logic [6:0]   lookupIdx = '0;
  logic [4:0]   lookupVec;
  logic         lookupMask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  msix_aperture dut_i (.*);

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d,
                          input logic [127:0] we = '0, input logic [127:0] wd = '0);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1; grpMaskWe = we; grpMaskWd = wd;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0; grpMaskWe = '0; grpMaskWd = '0;
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1; #1;
    d = prdata;
    @(posedge clk); #1;
    psel = 0; penable = 0;
  endtask

  function automatic logic [4:0] vecPat(input int t, input int k);
    return 5'((t * 7 + k) % 32);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [127:0] expMask;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // reset state: R2, R3, R8, R9
    check(maskOut === '1, "R3 reset maskOut", maskOut, '1);
    check(trafficClass === 3'd0, "R8 reset tc", trafficClass, 0);
    check(pready === 1'b1, "R1 pready", pready, 1);
    for (int t = 0; t < 128; t++) begin
      apbRead(12'h808 + 12'(16 * t), rd);
      check(rd === 32'd0, "R2 reset vector", rd, 0);
      apbRead(12'h80C + 12'(16 * t), rd);
      check(rd === 32'd1, "R3 reset mask", rd, 1);
    end

    // vector sweep with junk in upper bits: R1, R2
    for (int t = 0; t < 128; t++)
      apbWrite(12'h808 + 12'(16 * t), 32'hFFFF_FFE0 | 32'(vecPat(t, 3)));
    for (int t = 0; t < 128; t++) begin
      apbRead(12'h808 + 12'(16 * t), rd);
      check(rd === 32'(vecPat(t, 3)), "R2 vector readback", rd, vecPat(t, 3));
    end
    // lookup port: R9
    for (int t = 0; t < 128; t++) begin
      @(negedge clk); lookupIdx = 7'(t); #1;
      check(lookupVec === vecPat(t, 3), "R9 lookup vector", lookupVec, vecPat(t, 3));
      check(lookupMask === 1'b1, "R9 lookup mask", lookupMask, 1);
    end

    // words 0/1 ignored: R6
    for (int t = 0; t < 128; t += 5) begin
      apbWrite(12'h800 + 12'(16 * t), 32'hFFFF_FFFF);
      apbWrite(12'h804 + 12'(16 * t), 32'hFFFF_FFFE);
      apbRead(12'h800 + 12'(16 * t), rd);
      check(rd === 0, "R6 word0 zero", rd, 0);
      apbRead(12'h804 + 12'(16 * t), rd);
      check(rd === 0, "R6 word1 zero", rd, 0);
      apbRead(12'h808 + 12'(16 * t), rd);
      check(rd === 32'(vecPat(t, 3)), "R6 vector kept", rd, vecPat(t, 3));
      check(maskOut[t] === 1'b1, "R6 mask kept", maskOut[t], 1);
    end

    // table mask writes: R3
    expMask = '1;
    for (int t = 0; t < 128; t += 2) begin
      apbWrite(12'h80C + 12'(16 * t), 32'hFFFF_FFFE);
      expMask[t] = 1'b0;
    end
    check(maskOut === expMask, "R3 maskOut after table writes", maskOut, expMask);
    for (int t = 0; t < 8; t++) begin
      apbRead(12'h80C + 12'(16 * t), rd);
      check(rd === 32'(expMask[t]), "R3 mask readback", rd, expMask[t]);
    end

    // group updates: R4
    for (int g = 0; g < 4; g++) begin
      logic [127:0] we, wd;
      we = '0; wd = '0;
      for (int b = 0; b < 32; b += 3) begin
        we[g * 32 + b] = 1'b1;
        wd[g * 32 + b] = ~expMask[g * 32 + b];
      end
      @(negedge clk); grpMaskWe = we; grpMaskWd = wd;
      @(negedge clk); grpMaskWe = '0; grpMaskWd = '0;
      expMask = (expMask & ~we) | (wd & we);
      check(maskOut === expMask, "R4 group update", maskOut, expMask);
      apbRead(12'h80C + 12'(16 * (g * 32 + 3)), rd);
      check(rd === 32'(expMask[g * 32 + 3]), "R4 table view of group update", rd, expMask[g * 32 + 3]);
    end

    // same-cycle conflict: R5 (entry 40 table=0 vs group=1; entry 41 group only)
    begin
      logic [127:0] we, wd;
      we = '0; wd = '0;
      we[40] = 1; wd[40] = 1;
      we[41] = 1; wd[41] = ~expMask[41];
      apbWrite(12'h80C + 12'(16 * 40), 32'h0, we, wd);
      expMask[40] = 1'b0;
      expMask[41] = wd[41];
      check(maskOut === expMask, "R5 conflict table wins", maskOut, expMask);
      we = '0; wd = '0; we[40] = 1; wd[40] = 0;
      apbWrite(12'h80C + 12'(16 * 40), 32'h1, we, wd);
      expMask[40] = 1'b1;
      check(maskOut[40] === 1'b1, "R5 conflict table wins set", maskOut[40], 1);
      apbRead(12'h80C + 12'(16 * 41), rd);
      check(rd === 32'(expMask[41]), "R5 bystander update", rd, expMask[41]);
    end

    // pending image: R7
    for (int p = 0; p < 3; p++) begin
      for (int t = 0; t < 128; t++) causeIn[t] = ((t * (p + 3)) % 5) < 2;
      for (int g = 0; g < 4; g++) begin
        apbWrite(12'h3F0 + 12'(4 * g), 32'hA5A5_5A5A);
        apbRead(12'h3F0 + 12'(4 * g), rd);
        check(rd === causeIn[g * 32 +: 32], "R7 pending word", rd, causeIn[g * 32 +: 32]);
      end
    end
    check(maskOut === expMask, "R7 pending writes no effect", maskOut, expMask);

    // traffic class: R8
    apbWrite(12'h3E0, 32'hFFFF_FFFD);
    apbRead(12'h3E0, rd);
    check(rd === 32'd5, "R8 tc readback", rd, 5);
    check(trafficClass === 3'd5, "R8 tc port", trafficClass, 5);

    // unmapped: R10
    apbWrite(12'h100, 32'hFFFF_FFFF);
    apbWrite(12'h3E4, 32'hFFFF_FFFF);
    apbRead(12'h100, rd);
    check(rd === 0, "R10 unmapped read", rd, 0);
    apbRead(12'h3E4, rd);
    check(rd === 0, "R10 unmapped near tc", rd, 0);
    check(trafficClass === 3'd5 && maskOut === expMask, "R10 no side effect", trafficClass, 5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule